// File: doc/BRIEF.md
# Retirement Trace Aligner

This block gathers what a simple in-order pipeline did for each instruction and emits one coherent trace record per retired instruction, so that an external checker can compare the core against a reference model step by step. The pipeline hands over each piece of information at the stage where it first exists. The fetch-side stage supplies the program counter, the following program counter and the instruction word. The execute stage supplies the memory request and the CSR update. The memory stage supplies the load data. Writeback supplies the register-file write. The retire strobe and the trap flag arrive in the retire cycle.

Each group of fields passes through its own delay line. The depth of each line is a parameter equal to the number of stages between the capture point and the retire stage. The pipeline is assumed to advance one stage per cycle, so after the delay all fields of an instruction line up with its retire strobe. They are then packed and registered into the record. A trapped instruction is still reported, marked as trapped, with its register and memory side effects removed. Setting the enable parameter to zero removes every delay register and ties the record outputs to zero.

Top module: `trc_retire_port`

## Requirements
- R1: `trc_valid_o` is high in exactly the cycle after each cycle in which `retire_i` is high, and low otherwise. This gives one record per retired instruction.
- R2: A record's `trc_pc_o` and `trc_pc_next_o` equal the values on `pc_i` and `pc_next_i` exactly `DLY_FETCH` cycles before the retire cycle.
- R3: A record's `trc_insn_o` equals the value on `insn_i` exactly `DLY_FETCH` cycles before the retire cycle.
- R4: `trc_rd_we_o` is high only if `rd_we_i` was high `DLY_RF` cycles before the retire cycle with a non-zero `rd_addr_i`. In that case address and data come from that cycle. Otherwise the write flag, address and data all read zero, so register x0 is never reported as written.
- R5: `trc_csr_we_o`, `trc_csr_addr_o` and `trc_csr_data_o` report the CSR update presented `DLY_CSR` cycles before the retire cycle. All three read zero when no update was presented.
- R6: The memory fields report the request presented `DLY_MREQ` cycles before the retire cycle: access flag, store flag (1 = store), address and byte-lane mask (bit i set = byte lane i, bits [8i+7:8i], accessed). Store data is reported only for stores. Load data is taken from `mem_rdata_i` `DLY_MRSP` cycles before the retire cycle and reported only for loads. Unused data fields read zero.
- R7: When `trap_i` is high with `retire_i`, the record has `trc_trap_o` set and reports no register write and no memory access. PCs, instruction word and CSR fields are still reported.
- R8: In reset and in every cycle without a record, all record outputs read zero.
- R9: With `ENABLE` = 0, every record output is constantly zero whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | XLEN | PC of the instruction at the fetch-side capture stage |
| pc_next_i | input | XLEN | PC of the instruction that follows it |
| insn_i | input | 32 | Instruction word at the fetch-side capture stage |
| rd_we_i | input | 1 | Register-file write at writeback capture stage |
| rd_addr_i | input | 5 | Destination register index |
| rd_data_i | input | XLEN | Value written to the register file |
| csr_we_i | input | 1 | CSR update at its capture stage |
| csr_addr_i | input | 12 | CSR address |
| csr_data_i | input | XLEN | New CSR value |
| mem_req_i | input | 1 | Memory access at request capture stage |
| mem_we_i | input | 1 | Access is a store |
| mem_addr_i | input | XLEN | Access address |
| mem_be_i | input | XLEN/8 | Byte-lane mask |
| mem_wdata_i | input | XLEN | Store data |
| mem_rdata_i | input | XLEN | Load data at response capture stage |
| retire_i | input | 1 | An instruction retires this cycle |
| trap_i | input | 1 | The retiring instruction trapped |
| trc_valid_o | output | 1 | Record present |
| trc_trap_o | output | 1 | Recorded instruction trapped |
| trc_pc_o | output | XLEN | PC of the retired instruction |
| trc_pc_next_o | output | XLEN | PC of the next instruction |
| trc_insn_o | output | 32 | Executed instruction word |
| trc_rd_we_o | output | 1 | Register write reported |
| trc_rd_addr_o | output | 5 | Written register index |
| trc_rd_data_o | output | XLEN | Written register value |
| trc_csr_we_o | output | 1 | CSR update reported |
| trc_csr_addr_o | output | 12 | Updated CSR address |
| trc_csr_data_o | output | XLEN | Updated CSR value |
| trc_mem_req_o | output | 1 | Memory access reported |
| trc_mem_we_o | output | 1 | Reported access is a store |
| trc_mem_addr_o | output | XLEN | Access address |
| trc_mem_be_o | output | XLEN/8 | Byte-lane mask |
| trc_mem_wdata_o | output | XLEN | Store data |
| trc_mem_rdata_o | output | XLEN | Load data |

## Verification
A record is due one cycle after its retire strobe. A field captured at a stage with delay D therefore comes from the input presented D+1 cycles before the record appears. The bench drives a new instruction into every stage each cycle, using data computed from its index. At each falling edge it first checks the record belonging to the retire strobe of the previous cycle, and only then drives the next inputs. The delays cover a zero-depth pass-through, one- and two-stage lines and the three-stage fetch line. The instruction indices sweep bubbles, traps, x0 writes, loads, stores and every byte-lane shape, and a second instance with the block compiled out is checked for constant zero every cycle.

// File: rtl/trc_pkg.sv
package trc_pkg;
   localparam int unsigned TRC_INSN_W  = 32;
   localparam int unsigned TRC_REGA_W  = 5;
   localparam int unsigned TRC_CSRA_W  = 12;
   localparam int unsigned TRC_MAX_DLY = 16;
endpackage

// File: rtl/trc_delay_line.sv
module trc_delay_line #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (W == 0) begin : g_bad_w
      $error("trc_delay_line: W must be non-zero");
   end

   if (DEPTH == 0) begin : g_thru
      assign q_o = d_i;
   end else begin : g_shift
      logic [W-1:0] stg_q [DEPTH];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int i = 0; i < int'(DEPTH); i++) stg_q[i] <= '0;
         end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < int'(DEPTH); i++) stg_q[i] <= stg_q[i-1];
         end
      end
      assign q_o = stg_q[DEPTH-1];
   end
endmodule

// File: rtl/trc_record_pack.sv
module trc_record_pack
   import trc_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   localparam int unsigned BEW = XLEN / 8
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  retire_i,
   input  logic                  trap_i,
   input  logic [XLEN-1:0]       pc_i,
   input  logic [XLEN-1:0]       pc_next_i,
   input  logic [TRC_INSN_W-1:0] insn_i,
   input  logic                  rd_we_i,
   input  logic [TRC_REGA_W-1:0] rd_addr_i,
   input  logic [XLEN-1:0]       rd_data_i,
   input  logic                  csr_we_i,
   input  logic [TRC_CSRA_W-1:0] csr_addr_i,
   input  logic [XLEN-1:0]       csr_data_i,
   input  logic                  mem_req_i,
   input  logic                  mem_we_i,
   input  logic [XLEN-1:0]       mem_addr_i,
   input  logic [BEW-1:0]        mem_be_i,
   input  logic [XLEN-1:0]       mem_wdata_i,
   input  logic [XLEN-1:0]       mem_rdata_i,
   output logic                  trc_valid_o,
   output logic                  trc_trap_o,
   output logic [XLEN-1:0]       trc_pc_o,
   output logic [XLEN-1:0]       trc_pc_next_o,
   output logic [TRC_INSN_W-1:0] trc_insn_o,
   output logic                  trc_rd_we_o,
   output logic [TRC_REGA_W-1:0] trc_rd_addr_o,
   output logic [XLEN-1:0]       trc_rd_data_o,
   output logic                  trc_csr_we_o,
   output logic [TRC_CSRA_W-1:0] trc_csr_addr_o,
   output logic [XLEN-1:0]       trc_csr_data_o,
   output logic                  trc_mem_req_o,
   output logic                  trc_mem_we_o,
   output logic [XLEN-1:0]       trc_mem_addr_o,
   output logic [BEW-1:0]        trc_mem_be_o,
   output logic [XLEN-1:0]       trc_mem_wdata_o,
   output logic [XLEN-1:0]       trc_mem_rdata_o
);
   logic clean, rd_hit, csr_hit, mem_hit, st_hit, ld_hit;

   assign clean   = retire_i & ~trap_i;
   assign rd_hit  = clean & rd_we_i & (rd_addr_i != '0);
   assign csr_hit = retire_i & csr_we_i;
   assign mem_hit = clean & mem_req_i;
   assign st_hit  = mem_hit & mem_we_i;
   assign ld_hit  = mem_hit & ~mem_we_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         trc_valid_o     <= 1'b0;
         trc_trap_o      <= 1'b0;
         trc_pc_o        <= '0;
         trc_pc_next_o   <= '0;
         trc_insn_o      <= '0;
         trc_rd_we_o     <= 1'b0;
         trc_rd_addr_o   <= '0;
         trc_rd_data_o   <= '0;
         trc_csr_we_o    <= 1'b0;
         trc_csr_addr_o  <= '0;
         trc_csr_data_o  <= '0;
         trc_mem_req_o   <= 1'b0;
         trc_mem_we_o    <= 1'b0;
         trc_mem_addr_o  <= '0;
         trc_mem_be_o    <= '0;
         trc_mem_wdata_o <= '0;
         trc_mem_rdata_o <= '0;
      end else begin
         trc_valid_o     <= retire_i;
         trc_trap_o      <= retire_i & trap_i;
         trc_pc_o        <= retire_i ? pc_i      : '0;
         trc_pc_next_o   <= retire_i ? pc_next_i : '0;
         trc_insn_o      <= retire_i ? insn_i    : '0;
         trc_rd_we_o     <= rd_hit;
         trc_rd_addr_o   <= rd_hit ? rd_addr_i : '0;
         trc_rd_data_o   <= rd_hit ? rd_data_i : '0;
         trc_csr_we_o    <= csr_hit;
         trc_csr_addr_o  <= csr_hit ? csr_addr_i : '0;
         trc_csr_data_o  <= csr_hit ? csr_data_i : '0;
         trc_mem_req_o   <= mem_hit;
         trc_mem_we_o    <= st_hit;
         trc_mem_addr_o  <= mem_hit ? mem_addr_i  : '0;
         trc_mem_be_o    <= mem_hit ? mem_be_i    : '0;
         trc_mem_wdata_o <= st_hit  ? mem_wdata_i : '0;
         trc_mem_rdata_o <= ld_hit  ? mem_rdata_i : '0;
      end
   end

   AST_RECORD_PER_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      retire_i |=> trc_valid_o);  // R1
   AST_NO_RECORD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !retire_i |=> !trc_valid_o);  // R1
   AST_TRAP_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (retire_i && trap_i) |=> (trc_trap_o && !trc_rd_we_o && !trc_mem_req_o));  // R7
   AST_NO_X0_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trc_rd_we_o |-> (trc_rd_addr_o != '0));  // R4
   AST_LOAD_STORE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !((trc_mem_wdata_o != '0) && (trc_mem_rdata_o != '0)));  // R6
   AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !trc_valid_o |-> (trc_pc_o == '0 && trc_insn_o == '0 && !trc_csr_we_o
                        && !trc_mem_req_o && !trc_trap_o));  // R8
endmodule

// File: rtl/trc_retire_port.sv
module trc_retire_port
   import trc_pkg::*;
#(
   parameter bit          ENABLE    = 1'b1,
   parameter int unsigned XLEN      = 32,
   parameter int unsigned DLY_FETCH = 3,
   parameter int unsigned DLY_RF    = 0,
   parameter int unsigned DLY_CSR   = 2,
   parameter int unsigned DLY_MREQ  = 2,
   parameter int unsigned DLY_MRSP  = 1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [XLEN-1:0]         pc_i,
   input  logic [XLEN-1:0]         pc_next_i,
   input  logic [31:0]             insn_i,
   input  logic                    rd_we_i,
   input  logic [4:0]              rd_addr_i,
   input  logic [XLEN-1:0]         rd_data_i,
   input  logic                    csr_we_i,
   input  logic [11:0]             csr_addr_i,
   input  logic [XLEN-1:0]         csr_data_i,
   input  logic                    mem_req_i,
   input  logic                    mem_we_i,
   input  logic [XLEN-1:0]         mem_addr_i,
   input  logic [XLEN/8-1:0]       mem_be_i,
   input  logic [XLEN-1:0]         mem_wdata_i,
   input  logic [XLEN-1:0]         mem_rdata_i,
   input  logic                    retire_i,
   input  logic                    trap_i,
   output logic                    trc_valid_o,
   output logic                    trc_trap_o,
   output logic [XLEN-1:0]         trc_pc_o,
   output logic [XLEN-1:0]         trc_pc_next_o,
   output logic [31:0]             trc_insn_o,
   output logic                    trc_rd_we_o,
   output logic [4:0]              trc_rd_addr_o,
   output logic [XLEN-1:0]         trc_rd_data_o,
   output logic                    trc_csr_we_o,
   output logic [11:0]             trc_csr_addr_o,
   output logic [XLEN-1:0]         trc_csr_data_o,
   output logic                    trc_mem_req_o,
   output logic                    trc_mem_we_o,
   output logic [XLEN-1:0]         trc_mem_addr_o,
   output logic [XLEN/8-1:0]       trc_mem_be_o,
   output logic [XLEN-1:0]         trc_mem_wdata_o,
   output logic [XLEN-1:0]         trc_mem_rdata_o
);
   localparam int unsigned BEW   = XLEN / 8;
   localparam int unsigned FET_W = 2 * XLEN + TRC_INSN_W;
   localparam int unsigned RF_W  = 1 + TRC_REGA_W + XLEN;
   localparam int unsigned CSR_W = 1 + TRC_CSRA_W + XLEN;
   localparam int unsigned MRQ_W = 2 + 2 * XLEN + BEW;

   if (XLEN % 8 != 0 || XLEN < 32) begin : g_bad_xlen
      $error("trc_retire_port: XLEN must be a multiple of 8 and at least 32");
   end
   if (DLY_FETCH > TRC_MAX_DLY || DLY_RF > TRC_MAX_DLY || DLY_CSR > TRC_MAX_DLY
       || DLY_MREQ > TRC_MAX_DLY || DLY_MRSP > TRC_MAX_DLY) begin : g_bad_dly
      $error("trc_retire_port: stage delay exceeds TRC_MAX_DLY");
   end

   if (ENABLE) begin : g_on
      logic [FET_W-1:0] fet_a;
      logic [RF_W-1:0]  rf_a;
      logic [CSR_W-1:0] csr_a;
      logic [MRQ_W-1:0] mrq_a;
      logic [XLEN-1:0]  mrs_a;

      trc_delay_line #(.W(FET_W), .DEPTH(DLY_FETCH)) u_fet (
         .clk_i, .rst_ni, .d_i({pc_i, pc_next_i, insn_i}), .q_o(fet_a));
      trc_delay_line #(.W(RF_W), .DEPTH(DLY_RF)) u_rf (
         .clk_i, .rst_ni, .d_i({rd_we_i, rd_addr_i, rd_data_i}), .q_o(rf_a));
      trc_delay_line #(.W(CSR_W), .DEPTH(DLY_CSR)) u_csr (
         .clk_i, .rst_ni, .d_i({csr_we_i, csr_addr_i, csr_data_i}), .q_o(csr_a));
      trc_delay_line #(.W(MRQ_W), .DEPTH(DLY_MREQ)) u_mrq (
         .clk_i, .rst_ni,
         .d_i({mem_req_i, mem_we_i, mem_addr_i, mem_be_i, mem_wdata_i}), .q_o(mrq_a));
      trc_delay_line #(.W(XLEN), .DEPTH(DLY_MRSP)) u_mrs (
         .clk_i, .rst_ni, .d_i(mem_rdata_i), .q_o(mrs_a));

      trc_record_pack #(.XLEN(XLEN)) u_pack (
         .clk_i, .rst_ni,
         .retire_i, .trap_i,
         .pc_i       (fet_a[FET_W-1 -: XLEN]),
         .pc_next_i  (fet_a[TRC_INSN_W +: XLEN]),
         .insn_i     (fet_a[TRC_INSN_W-1:0]),
         .rd_we_i    (rf_a[RF_W-1]),
         .rd_addr_i  (rf_a[XLEN +: TRC_REGA_W]),
         .rd_data_i  (rf_a[XLEN-1:0]),
         .csr_we_i   (csr_a[CSR_W-1]),
         .csr_addr_i (csr_a[XLEN +: TRC_CSRA_W]),
         .csr_data_i (csr_a[XLEN-1:0]),
         .mem_req_i  (mrq_a[MRQ_W-1]),
         .mem_we_i   (mrq_a[MRQ_W-2]),
         .mem_addr_i (mrq_a[XLEN+BEW +: XLEN]),
         .mem_be_i   (mrq_a[XLEN +: BEW]),
         .mem_wdata_i(mrq_a[XLEN-1:0]),
         .mem_rdata_i(mrs_a),
         .trc_valid_o, .trc_trap_o, .trc_pc_o, .trc_pc_next_o, .trc_insn_o,
         .trc_rd_we_o, .trc_rd_addr_o, .trc_rd_data_o,
         .trc_csr_we_o, .trc_csr_addr_o, .trc_csr_data_o,
         .trc_mem_req_o, .trc_mem_we_o, .trc_mem_addr_o, .trc_mem_be_o,
         .trc_mem_wdata_o, .trc_mem_rdata_o);
   end else begin : g_off
      logic off_unused;
      assign off_unused = ^{clk_i, rst_ni, pc_i, pc_next_i, insn_i, rd_we_i, rd_addr_i,
                            rd_data_i, csr_we_i, csr_addr_i, csr_data_i, mem_req_i,
                            mem_we_i, mem_addr_i, mem_be_i, mem_wdata_i, mem_rdata_i,
                            retire_i, trap_i};
      assign trc_valid_o     = 1'b0;
      assign trc_trap_o      = 1'b0;
      assign trc_pc_o        = '0;
      assign trc_pc_next_o   = '0;
      assign trc_insn_o      = '0;
      assign trc_rd_we_o     = 1'b0;
      assign trc_rd_addr_o   = '0;
      assign trc_rd_data_o   = '0;
      assign trc_csr_we_o    = 1'b0;
      assign trc_csr_addr_o  = '0;
      assign trc_csr_data_o  = '0;
      assign trc_mem_req_o   = 1'b0;
      assign trc_mem_we_o    = 1'b0;
      assign trc_mem_addr_o  = '0;
      assign trc_mem_be_o    = '0;
      assign trc_mem_wdata_o = '0;
      assign trc_mem_rdata_o = '0;
   end
endmodule

// File: tb/sim_trc_retire_port.sv
module sim_trc_retire_port;
   localparam int XL = 32;
   localparam int DF = 3, DR = 0, DC = 2, DQ = 2, DS = 1;
   localparam int NINS = 240;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [XL-1:0] pc, pcn, rdd, csrd, maddr, mwd, mrd;
   logic [31:0] insn;
   logic rdwe, csrwe, mreq, mwe, ret, trap;
   logic [4:0] rda;
   logic [11:0] csra;
   logic [3:0] mbe;

   logic v, tr, rwe, cwe, mq, mw;
   logic [XL-1:0] opc, opcn, ordd, ocd, oma, omw, omr;
   logic [31:0] oin;
   logic [4:0] ora;
   logic [11:0] oca;
   logic [3:0] obe;

   logic fv, ftr, frwe, fcwe, fmq, fmw;
   logic [XL-1:0] fpc, fpcn, frdd, fcd, fma, fmwd, fmr;
   logic [31:0] fin;
   logic [4:0] fra;
   logic [11:0] fca;
   logic [3:0] fbe;

   trc_retire_port #(.ENABLE(1'b1), .XLEN(XL), .DLY_FETCH(DF), .DLY_RF(DR),
      .DLY_CSR(DC), .DLY_MREQ(DQ), .DLY_MRSP(DS)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .pc_next_i(pcn), .insn_i(insn),
      .rd_we_i(rdwe), .rd_addr_i(rda), .rd_data_i(rdd), .csr_we_i(csrwe),
      .csr_addr_i(csra), .csr_data_i(csrd), .mem_req_i(mreq), .mem_we_i(mwe),
      .mem_addr_i(maddr), .mem_be_i(mbe), .mem_wdata_i(mwd), .mem_rdata_i(mrd),
      .retire_i(ret), .trap_i(trap),
      .trc_valid_o(v), .trc_trap_o(tr), .trc_pc_o(opc), .trc_pc_next_o(opcn),
      .trc_insn_o(oin), .trc_rd_we_o(rwe), .trc_rd_addr_o(ora), .trc_rd_data_o(ordd),
      .trc_csr_we_o(cwe), .trc_csr_addr_o(oca), .trc_csr_data_o(ocd),
      .trc_mem_req_o(mq), .trc_mem_we_o(mw), .trc_mem_addr_o(oma), .trc_mem_be_o(obe),
      .trc_mem_wdata_o(omw), .trc_mem_rdata_o(omr));

   trc_retire_port #(.ENABLE(1'b0), .XLEN(XL), .DLY_FETCH(DF), .DLY_RF(DR),
      .DLY_CSR(DC), .DLY_MREQ(DQ), .DLY_MRSP(DS)) u_off (
      .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .pc_next_i(pcn), .insn_i(insn),
      .rd_we_i(rdwe), .rd_addr_i(rda), .rd_data_i(rdd), .csr_we_i(csrwe),
      .csr_addr_i(csra), .csr_data_i(csrd), .mem_req_i(mreq), .mem_we_i(mwe),
      .mem_addr_i(maddr), .mem_be_i(mbe), .mem_wdata_i(mwd), .mem_rdata_i(mrd),
      .retire_i(ret), .trap_i(trap),
      .trc_valid_o(fv), .trc_trap_o(ftr), .trc_pc_o(fpc), .trc_pc_next_o(fpcn),
      .trc_insn_o(fin), .trc_rd_we_o(frwe), .trc_rd_addr_o(fra), .trc_rd_data_o(frdd),
      .trc_csr_we_o(fcwe), .trc_csr_addr_o(fca), .trc_csr_data_o(fcd),
      .trc_mem_req_o(fmq), .trc_mem_we_o(fmw), .trc_mem_addr_o(fma), .trc_mem_be_o(fbe),
      .trc_mem_wdata_o(fmwd), .trc_mem_rdata_o(fmr));

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // per-instruction stimulus, computed from the instruction index
   function automatic bit f_ret(int k);  return k >= 0 && (k % 7) != 6; endfunction
   function automatic bit f_trap(int k); return (k % 5) == 4; endfunction
   function automatic logic [31:0] f_pc(int k);  return 32'h100 + 32'(k) * 4; endfunction
   function automatic logic [31:0] f_pcn(int k);
      return ((k % 6) == 0) ? f_pc(k) + 32'(k) * 16 + 32'h40 : f_pc(k) + 4;
   endfunction
   function automatic logic [31:0] f_insn(int k); return 32'(k) * 32'h9E3779B1 + 32'h13; endfunction
   function automatic bit f_rdwe(int k); return (k % 3) != 0; endfunction
   function automatic logic [4:0] f_rda(int k); return 5'(k % 32); endfunction
   function automatic logic [31:0] f_rdd(int k); return (32'(k) * 32'h01010101) ^ 32'hA5; endfunction
   function automatic bit f_csrwe(int k); return (k % 4) == 1; endfunction
   function automatic logic [11:0] f_csra(int k); return 12'h300 + 12'(k % 8); endfunction
   function automatic logic [31:0] f_csrd(int k); return ~32'(k); endfunction
   function automatic bit f_mreq(int k); return (k % 2) == 0 || (k % 9) == 1; endfunction
   function automatic bit f_mwe(int k); return (k % 4) == 2 || (k % 9) == 1; endfunction
   function automatic logic [31:0] f_madr(int k); return 32'h2000 + 32'(k) * 4 + 32'(k % 4); endfunction
   function automatic logic [3:0] f_mbe(int k);
      case (k % 3)
         0: return 4'b0001 << (k % 4);
         1: return 4'b0011 << (2 * ((k / 3) % 2));
         default: return 4'b1111;
      endcase
   endfunction
   function automatic logic [31:0] f_mwd(int k); return (32'(k) << 8) | 32'(k) | 32'h1; endfunction
   function automatic logic [31:0] f_mrd(int k); return 32'hC0DE0000 | 32'(k); endfunction

   // drive cycle c: instruction k retires in cycle k+DF, field X is presented DLY_X earlier
   task automatic drive(int c);
      int kf = c, kr = c - DF + DR, kc = c - DF + DC, kq = c - DF + DQ, ks = c - DF + DS;
      int kt = c - DF;
      pc    = (kf >= 0) ? f_pc(kf)   : '0;
      pcn   = (kf >= 0) ? f_pcn(kf)  : '0;
      insn  = (kf >= 0) ? f_insn(kf) : '0;
      rdwe  = (kr >= 0) ? f_rdwe(kr) : 1'b0;
      rda   = (kr >= 0) ? f_rda(kr)  : '0;
      rdd   = (kr >= 0) ? f_rdd(kr)  : '0;
      csrwe = (kc >= 0) ? f_csrwe(kc): 1'b0;
      csra  = (kc >= 0) ? f_csra(kc) : '0;
      csrd  = (kc >= 0) ? f_csrd(kc) : '0;
      mreq  = (kq >= 0) ? f_mreq(kq) : 1'b0;
      mwe   = (kq >= 0) ? f_mwe(kq)  : 1'b0;
      maddr = (kq >= 0) ? f_madr(kq) : '0;
      mbe   = (kq >= 0) ? f_mbe(kq)  : '0;
      mwd   = (kq >= 0) ? f_mwd(kq)  : '0;
      mrd   = (ks >= 0) ? f_mrd(ks)  : '0;
      ret   = f_ret(kt);
      trap  = (kt >= 0) ? f_trap(kt) : 1'b0;
   endtask

   task automatic check_rec(int k);
      bit rv = f_ret(k);
      bit tp = rv && f_trap(k);
      bit cl = rv && !tp;
      bit rw = cl && f_rdwe(k) && (f_rda(k) != 0);
      bit cw = rv && f_csrwe(k);
      bit mh = cl && f_mreq(k);
      bit st = mh && f_mwe(k);
      bit ld = mh && !f_mwe(k);
      chk("R1", "valid", 128'(v), 128'(rv));
      chk("R7", "trap", 128'(tr), 128'(tp));
      chk("R2", "pc/next", {opc, opcn}, rv ? {f_pc(k), f_pcn(k)} : 64'h0);
      chk("R3", "insn", 128'(oin), rv ? 128'(f_insn(k)) : 128'h0);
      chk("R4", "rd", {rwe, ora, ordd}, rw ? {1'b1, f_rda(k), f_rdd(k)} : 38'h0);
      chk("R5", "csr", {cwe, oca, ocd}, cw ? {1'b1, f_csra(k), f_csrd(k)} : 45'h0);
      chk("R6", "mem", {mq, mw, oma, obe, omw, omr},
          {mh, st, mh ? f_madr(k) : 32'h0, mh ? f_mbe(k) : 4'h0,
           st ? f_mwd(k) : 32'h0, ld ? f_mrd(k) : 32'h0});
      if (!rv)
         chk("R8", "idle zero", 128'({tr, opc, opcn, oin, rwe, cwe, mq}), 128'h0);
      chk("R9", "disabled zero",
          128'(|{fv, ftr, fpc, fpcn, fin, frwe, fra, frdd, fcwe, fca, fcd,
                 fmq, fmw, fma, fbe, fmwd, fmr}), 128'h0);
   endtask

   initial begin
      drive(-100);
      ret = 1'b1; trap = 1'b1; rdwe = 1'b1; rda = 5'd3; mreq = 1'b1;
      repeat (4) @(negedge clk);
      // R8: reset holds the record at zero even with retire asserted
      chk("R8", "reset record", 128'({v, tr, opc, oin, rwe, cwe, mq, omr}), 128'h0);
      chk("R9", "reset disabled", 128'({fv, fpc, fmq}), 128'h0);
      drive(-100);
      @(negedge clk);
      rst_n = 1'b1;
      drive(0);
      for (int c = 1; c <= NINS + DF + 2; c++) begin
         @(negedge clk);
         if (c - 1 - DF >= 0) check_rec(c - 1 - DF);
         else chk("R8", "fill zero", 128'({v, opc, oin, rwe, mq}), 128'h0);
         drive(c);
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule